// File: doc/BRIEF.md
# Fractional Sample-Rate Strobe Generator

This block turns a master sample-rate reference into a slower sample strobe whose rate is a rational fraction of the master. Three master references arrive as single-cycle strobes in the system clock domain: a 48 kHz reference, a 44.1 kHz reference, and a clock recovered by a digital audio receiver. A select register picks one of them. A ratio register holds an increment and an encoded modulus. An accumulator advances by the increment on every selected reference strobe. When it reaches the modulus it wraps and emits one output strobe. Over time the output rate is therefore master × inc / mod.

The modulus is never stored as a plain value. Software writes a control field equal to (inc − mod − 1) truncated to 16 bits, and the block recovers the modulus as (inc − 1 − field) modulo 2^16. The normal setting uses inc = 4 and mod = 4 × master / target. For example, 8 kHz from the 48 kHz reference uses mod = 24, and 22.05 kHz from the 44.1 kHz reference uses mod = 8. A write to either register restarts the accumulator from zero, so each new ratio starts from a known phase. A codec channel normally owns one instance of this generator.

Top module: `rate_strobe_gen`

## Requirements
- R1: After reset, the select field is 0, the increment is 0 and the modulus field is 0. With these values `rate_strobe` stays low whatever the reference inputs do.
- R2: Select field `cfg_wdata[1:0]`, written by `cfg_sel_we`, picks the reference: 0 takes `ref_tick[0]` (48 kHz), 1 takes `ref_tick[1]` (44.1 kHz), 2 takes `ref_tick[2]` (receiver clock). Strobes on the references that are not selected have no effect.
- R3: Select value 3 is reserved. With it selected, no reference strobe advances the accumulator and `rate_strobe` stays low.
- R4: A `cfg_ratio_we` write stores the increment from `cfg_wdata[15:0]` and the modulus field from `cfg_wdata[31:16]`. The modulus used is (increment − 1 − field) modulo 65536.
- R5: On each selected reference strobe, the accumulator adds the increment. If the sum is at least the modulus, the modulus is subtracted and `rate_strobe` is high for exactly the next clock cycle. A strobe never appears unless a selected reference strobe occurred in the cycle before.
- R6: Starting from a restart, N selected reference strobes produce exactly floor(N × inc / mod) output strobes once the last one has been processed.
- R7: A modulus that decodes to 0, or to a value below the increment, disables the generator, and `rate_strobe` stays low.
- R8: A write to either register sets the accumulator to zero. A reference strobe in the same cycle as a write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel_we | input | 1 | Write strobe for the reference-select register |
| cfg_ratio_we | input | 1 | Write strobe for the increment/modulus register |
| cfg_wdata | input | 32 | Write data for both registers |
| ref_tick | input | 3 | Master reference strobes: 48 kHz, 44.1 kHz, receiver |
| rate_strobe | output | 1 | One-cycle output sample strobe |

## Verification
The assertions assume that each reference input is a synchronous, single-cycle-wide strobe in the `clk` domain. They also assume that register writes come as one-cycle `cfg_*_we` pulses, with `cfg_wdata` valid in that cycle. The stimulus drives every input on the falling edge, so each reference strobe and write lands in exactly one rising edge. Reference patterns are random per cycle, and several references pulse at once, so the selection logic is exercised. Dense patterns with strobes back to back test continuous wrapping at inc = mod. Writes sometimes coincide with a selected strobe, to cover the discard rule.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  localparam int unsigned NUM_REFS = 3;

  typedef enum logic [1:0] {
    REF_48K   = 2'd0,
    REF_44K1  = 2'd1,
    REF_RXCLK = 2'd2,
    REF_NONE  = 2'd3
  } ref_sel_e;
endpackage

// File: rtl/rsg_ctrl_regs.sv
module rsg_ctrl_regs #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_we,
  input  logic               ratio_we,
  input  logic [2*CNT_W-1:0] wdata,
  output logic [SEL_W-1:0]   sel_q,
  output logic [CNT_W-1:0]   inc_q,
  output logic [CNT_W-1:0]   modctl_q,
  output logic               restart
);
  // either write restarts the accumulator phase
  assign restart = sel_we | ratio_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      inc_q    <= '0;
      modctl_q <= '0;
    end else begin
      if (sel_we)   sel_q <= wdata[SEL_W-1:0];
      if (ratio_we) begin
        inc_q    <= wdata[CNT_W-1:0];
        modctl_q <= wdata[2*CNT_W-1:CNT_W];
      end
    end
  end

  // R2: select only moves on its own write
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_we |=> $stable(sel_q));
  // R4: ratio fields only move on their own write
  p_ratio_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ratio_we |=> ($stable(inc_q) && $stable(modctl_q)));
endmodule

// File: rtl/rsg_ref_mux.sv
module rsg_ref_mux #(
  parameter int unsigned NUM_REFS = 3,
  parameter int unsigned SEL_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_W-1:0]    sel,
  input  logic [NUM_REFS-1:0] refs,
  output logic                tick
);
  logic [NUM_REFS-1:0] hit;

  generate
    for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
      assign hit[g] = refs[g] && (sel == SEL_W'(g));
    end
  endgenerate

  assign tick = |hit;

  // R3: a select value beyond the reference list yields no tick
  p_reserved_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel) >= NUM_REFS) |-> !tick);
  // R2: a tick only comes from the selected reference
  p_tick_sourced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ((int'(sel) < NUM_REFS) && $onehot0(hit)));
endmodule

// File: rtl/rsg_accum.sv
module rsg_accum #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] inc,
  input  logic [CNT_W-1:0] modctl,
  output logic             strobe
);
  localparam int unsigned SUM_W = CNT_W + 1;

  // modulus = inc - 1 - field, wrapped to CNT_W bits
  function automatic logic [CNT_W-1:0] decode_mod(input logic [CNT_W-1:0] i,
                                                  input logic [CNT_W-1:0] f);
    return i - CNT_W'(1) - f;
  endfunction

  function automatic logic ratio_ok(input logic [CNT_W-1:0] i,
                                    input logic [CNT_W-1:0] m);
    return (m != '0) && (m >= i);
  endfunction

  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] modulus;
  logic             enabled;
  logic             step_ev;
  logic [SUM_W-1:0] sum;
  logic             wrap_ev;

  assign modulus = decode_mod(inc, modctl);
  assign enabled = ratio_ok(inc, modulus);
  assign step_ev = tick && enabled && !restart;
  assign sum     = {1'b0, acc_q} + {1'b0, inc};
  assign wrap_ev = step_ev && (sum >= {1'b0, modulus});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      strobe <= 1'b0;
    end else if (restart) begin
      acc_q  <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= wrap_ev;
      if (step_ev) begin
        acc_q <= wrap_ev ? CNT_W'(sum - {1'b0, modulus}) : CNT_W'(sum);
      end
    end
  end

  // R5: an output strobe needs an accepted tick one cycle earlier
  p_strobe_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> $past(step_ev));
  // R5: the phase stays below the modulus while enabled
  p_acc_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    enabled |-> (acc_q < modulus));
  // R8: a register write leaves a zero phase and no strobe
  p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (acc_q == '0 && !strobe));
  // R7: a disabled ratio gives no strobe
  p_disabled_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> !strobe);
endmodule

// File: rtl/rate_strobe_gen.sv
module rate_strobe_gen #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned NUM_REFS = rsg_pkg::NUM_REFS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_sel_we,
  input  logic               cfg_ratio_we,
  input  logic [2*CNT_W-1:0] cfg_wdata,
  input  logic [NUM_REFS-1:0] ref_tick,
  output logic               rate_strobe
);
  localparam int unsigned SEL_W = $clog2(NUM_REFS + 1);

  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] inc_q;
  logic [CNT_W-1:0] modctl_q;
  logic             restart;
  logic             sel_tick;

  rsg_ctrl_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_we   (cfg_sel_we),
    .ratio_we (cfg_ratio_we),
    .wdata    (cfg_wdata),
    .sel_q    (sel_q),
    .inc_q    (inc_q),
    .modctl_q (modctl_q),
    .restart  (restart)
  );

  rsg_ref_mux #(.NUM_REFS(NUM_REFS), .SEL_W(SEL_W)) u_mux (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel_q),
    .refs  (ref_tick),
    .tick  (sel_tick)
  );

  rsg_accum #(.CNT_W(CNT_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (sel_tick),
    .restart (restart),
    .inc     (inc_q),
    .modctl  (modctl_q),
    .strobe  (rate_strobe)
  );

  // R1: nothing comes out while the default configuration holds
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_q == '0) |=> !rate_strobe);
endmodule

// File: tb/tb_rate_strobe_gen.sv
`timescale 1ns/1ps
module tb_rate_strobe_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_sel_we = 1'b0;
  logic        cfg_ratio_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  ref_tick = '0;
  logic        rate_strobe;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int obs_cnt = 0;
  bit done = 0;

  // independent reference state
  int m_sel = 0, m_inc = 0, m_fld = 0, m_acc = 0;
  int sel_ticks = 0;

  bit    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  rate_strobe_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_sel_we(cfg_sel_we),
    .cfg_ratio_we(cfg_ratio_we), .cfg_wdata(cfg_wdata),
    .ref_tick(ref_tick), .rate_strobe(rate_strobe)
  );

  function automatic int mod_of(int inc, int fld);
    return (inc + 65535 - fld) % 65536;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, push expected output
  task automatic drive(logic [2:0] refs, bit swe, bit rwe, logic [31:0] wd, string tag);
    int  md;
    bit  en, tk, e;
    @(negedge clk);
    ref_tick = refs; cfg_sel_we = swe; cfg_ratio_we = rwe; cfg_wdata = wd;
    md = mod_of(m_inc, m_fld);
    en = (md != 0) && (md >= m_inc);
    tk = (m_sel < 3) && refs[m_sel];
    e  = 1'b0;
    if (swe || rwe) begin
      if (swe) m_sel = int'(wd[1:0]);
      if (rwe) begin m_inc = int'(wd[15:0]); m_fld = int'(wd[31:16]); end
      m_acc = 0;
      sel_ticks = 0;
      obs_cnt = 0;
    end else if (tk && en) begin
      sel_ticks++;
      m_acc += m_inc;
      if (m_acc >= md) begin m_acc -= md; e = 1'b1; end
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compare after every rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, int'(rate_strobe), int'(e));
      if (rate_strobe) obs_cnt++;
    end
  end

  task automatic set_sel(int s, string tag);
    drive(3'b000, 1'b1, 1'b0, 32'(s), tag);
  endtask

  task automatic set_ratio(int inc, int md, logic [2:0] refs, string tag);
    logic [15:0] fld;
    fld = 16'((inc - md - 1) & 16'hFFFF);
    drive(refs, 1'b0, 1'b1, {fld, 16'(inc)}, tag);
  endtask

  task automatic run(int n, int dens, string tag);
    for (int i = 0; i < n; i++) begin
      logic [2:0] r;
      for (int k = 0; k < 3; k++) r[k] = (($urandom % 100) < dens);
      drive(r, 1'b0, 1'b0, 32'h0, tag);
    end
  endtask

  // R6: total strobe count after draining
  task automatic ratio_count(int inc, int md, string tag);
    int n;
    n = sel_ticks;
    drive(3'b000, 1'b0, 1'b0, 32'h0, tag);
    @(posedge clk); #2;
    check(tag, obs_cnt, (n * inc) / md);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(rate_strobe), 0);
    rst_n = 1'b1;
    run(40, 60, "R1");

    // R2 / R5: 8 kHz from 48 kHz, inc=4 mod=24
    set_sel(0, "R2");
    set_ratio(4, 24, 3'b000, "R4");
    run(600, 40, "R5");
    ratio_count(4, 24, "R6");

    // R2: 44.1 kHz reference, mod=8
    set_sel(1, "R2");
    set_ratio(4, 8, 3'b000, "R4");
    run(400, 50, "R2");
    ratio_count(4, 8, "R6");

    // R4: fractional ratio on receiver clock, inc=3 mod=7
    set_sel(2, "R2");
    set_ratio(3, 7, 3'b000, "R4");
    run(500, 70, "R4");
    ratio_count(3, 7, "R6");

    // R5: inc == mod, dense ticks give back-to-back strobes
    set_ratio(4, 4, 3'b000, "R5");
    run(60, 100, "R5");
    ratio_count(4, 4, "R6");

    // R8: write coinciding with a selected tick discards it
    set_ratio(4, 4, 3'b100, "R8");
    drive(3'b000, 1'b0, 1'b0, 32'h0, "R8");
    set_ratio(2, 5, 3'b000, "R8");
    run(3, 100, "R8");
    set_sel(2, "R8");
    run(6, 100, "R8");
    set_sel(2, "R8");
    run(100, 60, "R8");

    // R3: reserved select
    set_sel(3, "R3");
    set_ratio(4, 4, 3'b000, "R3");
    run(200, 90, "R3");
    check("R3", obs_cnt, 0);

    // R7: modulus below increment, and modulus zero
    set_sel(0, "R7");
    set_ratio(5, 3, 3'b000, "R7");
    run(150, 90, "R7");
    check("R7", obs_cnt, 0);
    drive(3'b000, 1'b0, 1'b1, {16'd3, 16'd4}, "R7");
    run(150, 90, "R7");
    check("R7", obs_cnt, 0);

    drive(3'b000, 1'b0, 1'b0, 32'h0, "R5");
    @(posedge clk); #3;
    done = 1;
  end

  initial begin
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule